// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of frame octets into a bit-serial HDLC/SDLC line signal. Octets arrive on a byte-wide valid/ready input, with a marker on the final octet of each frame. For every frame the framer optionally sends a programmable 8-bit preamble some number of times. It then sends an opening flag, the payload and a frame check sequence with zero-bit insertion, and a closing flag. Between frames it keeps the line busy with idle fill, which is either continuous ones or back-to-back flags.

The serial side advances one bit for each cycle in which the bit strobe `bit_stb` is high, so a baud-rate divider outside the block sets the line rate. The input follows the usual valid/ready rules. A producer raises `s_valid` with `s_data`, `s_last` and `s_nocrc` and holds them until a cycle in which `s_ready` is also high. The framer raises `s_ready` for a single strobe cycle at each octet boundary where it needs the next payload octet. It never takes an octet in any other cycle. If the producer has no octet ready when one is needed inside a frame, the framer aborts the frame and flags an underrun.

Configuration pins select the frame check sequence, the fill type, the preamble, transparent mode and line inversion. They are expected to stay steady while a frame is in flight.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Every frame starts with its own opening flag octet 0x7E and ends with its own closing flag 0x7E. No flag is shared between frames. A frame starts only at an octet boundary of the idle fill, after at least one fill octet.
- R2: Within the payload and the frame check sequence, a 0 bit is inserted after every run of five consecutive 1 bits. This includes a run that ends on the last bit of the field. Flags, preamble, fill and abort octets never receive inserted zeros.
- R3: Octets go out least significant bit first. With `cfg_crc32`=0 the check sequence is CRC-16 (x^16+x^12+x^5+1) over the payload. With `cfg_crc32`=1 it is the standard CRC-32. Both are computed LSB-first, preset to all ones, and sent complemented, low-order octet first.
- R4: Transparent mode applies when `cfg_crc_off`=1, or when `s_nocrc`=1 with the first octet of a frame. In this mode no check sequence is generated and the closing flag follows the last payload octet directly.
- R5: Idle fill is made of whole octets. With `cfg_fill_flags`=0 it is all ones; with `cfg_fill_flags`=1 it is repeated 0x7E octets.
- R6: With `cfg_pre_cnt`=N>0, the octet `cfg_pre_pat` is sent N times, LSB first and without zero insertion, directly before the opening flag. With N=0 no preamble is sent.
- R7: With `cfg_invert`=1 every bit on `ser_out` is the complement of the bit that would be sent otherwise, including fill, flags and inserted zeros.
- R8: `s_ready` is high only in cycles where `bit_stb` is high. An octet is taken in a cycle where `s_valid` and `s_ready` are both high. `ser_out` changes only in the cycle after a strobe, and by one bit per strobe.
- R9: An underrun occurs when no octet is valid at the point where the framer needs the next payload octet of a frame. The framer then sends eight 1 bits with no zero insertion as an abort, pulses `underrun` for one clock cycle, and returns to idle fill.
- R10: After reset `ser_out`=1, `s_ready`=0 and `underrun`=0. The first octet sent after reset is eight 1 bits, whatever the fill setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | Advance the serial output by one bit |
| s_data | input | 8 | Payload octet |
| s_last | input | 1 | Octet is the last of its frame |
| s_nocrc | input | 1 | With the first octet: send this frame without a generated check sequence |
| s_valid | input | 1 | Octet and sidebands valid |
| s_ready | output | 1 | Framer takes the octet this cycle |
| cfg_crc32 | input | 1 | 1: CRC-32, 0: CRC-16 |
| cfg_fill_flags | input | 1 | 1: flag fill, 0: ones fill |
| cfg_crc_off | input | 1 | Transparent mode for all frames |
| cfg_invert | input | 1 | Invert every line bit |
| cfg_pre_pat | input | 8 | Preamble octet |
| cfg_pre_cnt | input | 4 | Preamble repetitions, 0 for none |
| ser_out | output | 1 | Serial line bit |
| underrun | output | 1 | One-cycle pulse when a frame is aborted for lack of data |

## Verification
A wrong octet boundary counter shifts the flags off their octet alignment or drops them. This is visible on the line within eight bit times. A corrupted CRC register produces no wrong bit until the check-sequence octets of that same frame. Only a bench that recomputes the sequence sees it there. A run counter that is stuck or miscounting shows, inside the same frame, as six 1 bits in a row or as a stray 0 after a shorter run. Those errors break alignment against the closing flag. A wrong state after an underrun shows as a missing eight-ones abort within the octet that follows, or as a second underrun pulse.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_OPEN, S_DATA, S_FCS, S_CLOSE, S_ABORT
  } tx_st_e;

  localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
  localparam logic [7:0]  ONES_OCTET  = 8'hFF;
  localparam int          STUFF_RUN   = 5;
  localparam logic [31:0] POLY16_REFL = 32'h0000_8408;
  localparam logic [31:0] POLY32_REFL = 32'hEDB8_8320;

  // One octet through the reflected CRC, data LSB first.
  function automatic logic [31:0] crc_octet(input logic [31:0] c,
                                            input logic [7:0]  d,
                                            input logic        wide);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ (wide ? POLY32_REFL : POLY16_REFL);
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       feed,
  input  logic [7:0] data,
  input  logic       wide,
  input  logic       drain,
  output logic [7:0] fcs_octet
);
  localparam int CRC_W = 32;

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] seed;

  // CRC-16 lives in the low half with the upper half held at zero.
  assign seed      = wide ? {CRC_W{1'b1}} : 32'h0000_FFFF;
  assign fcs_octet = ~crc_q[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= {CRC_W{1'b1}};
    else if (feed)   crc_q <= crc_octet(start ? seed : crc_q, data, wide);
    else if (drain)  crc_q <= crc_q >> 8;
  end

endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_in,
  input  logic count_en,
  input  logic clr_run,
  input  logic invert,
  output logic stuff_now,
  output logic ser_out
);
  localparam int RUN_W = $clog2(RUN + 1);

  logic [RUN_W-1:0] run_q;

  assign stuff_now = (run_q == RUN_W'(RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      ser_out <= 1'b1;
    end else if (bit_stb) begin
      if (stuff_now) begin
        ser_out <= invert;
        run_q   <= '0;
      end else begin
        ser_out <= bit_in ^ invert;
        if (clr_run || !(count_en && bit_in)) run_q <= '0;
        else                                  run_q <= run_q + RUN_W'(1);
      end
    end
  end

  // R8: the line holds its bit between strobes
  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(ser_out));

  // R2: an inserted zero restarts the run, so insertion never repeats back to back
  a_r2_restart_after_stuff: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && stuff_now) |=> !stuff_now);

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int PRE_CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_stb,
  input  logic [7:0]           s_data,
  input  logic                 s_last,
  input  logic                 s_nocrc,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic                 cfg_crc32,
  input  logic                 cfg_fill_flags,
  input  logic                 cfg_crc_off,
  input  logic                 cfg_invert,
  input  logic [7:0]           cfg_pre_pat,
  input  logic [PRE_CNT_W-1:0] cfg_pre_cnt,
  output logic                 ser_out,
  output logic                 underrun
);
  localparam int OCT_W = 8;
  localparam int BC_W  = $clog2(OCT_W);

  tx_st_e               st;
  logic [OCT_W-1:0]     sh;
  logic [BC_W-1:0]      bc;
  logic [PRE_CNT_W-1:0] pre_left;
  logic [1:0]           fcs_left;
  logic                 last_q, nocrc_q;

  logic stuff_now, adv, oct_end, need_byte, take, starve;
  logic fcs_first, fcs_next;
  logic [7:0] fcs_octet, fill_octet;

  assign adv        = bit_stb & ~stuff_now;
  assign oct_end    = adv & (bc == BC_W'(OCT_W - 1));
  assign need_byte  = (st == S_OPEN) | ((st == S_DATA) & ~last_q);
  assign s_ready    = oct_end & need_byte;
  assign take       = s_ready & s_valid;
  assign starve     = s_ready & ~s_valid;
  assign fcs_first  = oct_end & (st == S_DATA) & last_q & ~nocrc_q;
  assign fcs_next   = oct_end & (st == S_FCS) & (fcs_left != 2'd0);
  assign fill_octet = cfg_fill_flags ? FLAG_OCTET : ONES_OCTET;

  hdlc_tx_crc crc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (st == S_OPEN),
    .feed      (take),
    .data      (s_data),
    .wide      (cfg_crc32),
    .drain     (fcs_first | fcs_next),
    .fcs_octet (fcs_octet)
  );

  hdlc_tx_stuffer #(.RUN(STUFF_RUN)) stuff_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .bit_in    (sh[0]),
    .count_en  ((st == S_DATA) | (st == S_FCS)),
    .clr_run   (starve),
    .invert    (cfg_invert),
    .stuff_now (stuff_now),
    .ser_out   (ser_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= ONES_OCTET;
      bc       <= '0;
      pre_left <= '0;
      fcs_left <= '0;
      last_q   <= 1'b0;
      nocrc_q  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= starve;
      if (adv) begin
        if (!oct_end) begin
          sh <= {1'b0, sh[OCT_W-1:1]};
          bc <= bc + BC_W'(1);
        end else begin
          bc <= '0;
          unique case (st)
            S_IDLE: begin
              if (s_valid && cfg_pre_cnt != '0) begin
                st       <= S_PRE;
                sh       <= cfg_pre_pat;
                pre_left <= cfg_pre_cnt - PRE_CNT_W'(1);
              end else if (s_valid) begin
                st <= S_OPEN;
                sh <= FLAG_OCTET;
              end else begin
                sh <= fill_octet;
              end
            end
            S_PRE: begin
              if (pre_left != '0) begin
                sh       <= cfg_pre_pat;
                pre_left <= pre_left - PRE_CNT_W'(1);
              end else begin
                st <= S_OPEN;
                sh <= FLAG_OCTET;
              end
            end
            S_OPEN, S_DATA: begin
              if (take) begin
                st     <= S_DATA;
                sh     <= s_data;
                last_q <= s_last;
                if (st == S_OPEN) nocrc_q <= s_nocrc | cfg_crc_off;
              end else if (starve) begin
                st <= S_ABORT;
                sh <= ONES_OCTET;
              end else if (nocrc_q) begin
                st <= S_CLOSE;
                sh <= FLAG_OCTET;
              end else begin
                st       <= S_FCS;
                sh       <= fcs_octet;
                fcs_left <= cfg_crc32 ? 2'd3 : 2'd1;
              end
            end
            S_FCS: begin
              if (fcs_left != 2'd0) begin
                sh       <= fcs_octet;
                fcs_left <= fcs_left - 2'd1;
              end else begin
                st <= S_CLOSE;
                sh <= FLAG_OCTET;
              end
            end
            default: begin
              st <= S_IDLE;
              sh <= fill_octet;
            end
          endcase
        end
      end
    end
  end

  // R8: octets are only taken on a strobe
  a_r8_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_stb);

  // R9: the underrun pulse coincides with the abort octet
  a_r9_abort_on_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (st == S_ABORT));

  // R9: one pulse per aborted frame
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  // R4: transparent frames never reach the check-sequence state
  a_r4_no_fcs_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FCS) |-> !nocrc_q);

  // R1: the opening octet is a flag
  a_r1_open_is_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPEN && bc == '0) |-> (sh == FLAG_OCTET));

endmodule

// File: tb/hdlc_tx_framer_tb_top.sv
`timescale 1ns/1ps
module hdlc_tx_framer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_last = 1'b0, s_nocrc = 1'b0, s_valid = 1'b0;
  logic       s_ready;
  logic       cfg_crc32 = 1'b0, cfg_fill_flags = 1'b0, cfg_crc_off = 1'b0, cfg_invert = 1'b0;
  logic [7:0] cfg_pre_pat = '0;
  logic [3:0] cfg_pre_cnt = '0;
  logic       ser_out, underrun;

  hdlc_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .s_data(s_data), .s_last(s_last), .s_nocrc(s_nocrc), .s_valid(s_valid), .s_ready(s_ready),
    .cfg_crc32(cfg_crc32), .cfg_fill_flags(cfg_fill_flags), .cfg_crc_off(cfg_crc_off),
    .cfg_invert(cfg_invert), .cfg_pre_pat(cfg_pre_pat), .cfg_pre_cnt(cfg_pre_cnt),
    .ser_out(ser_out), .underrun(underrun)
  );

  always #5 clk = ~clk;

  int   total = 0, bad = 0;
  logic cap_bits [0:8191];
  int   cap_n = 0;
  logic cap_on = 1'b0, stb_en = 1'b0, stb_q = 1'b0, prev_out = 1'b1;
  int   underruns = 0, ready_viol = 0, hold_viol = 0;

  logic [7:0] frm_d [0:5][0:11];
  int         frm_len [0:5];
  bit         frm_nc [0:5];
  bit         frm_ab [0:5];
  bit         exp_q [$];
  int         run_ones;

  always @(posedge clk) stb_q <= bit_stb;

  initial forever begin
    @(negedge clk);
    bit_stb <= stb_en && ($urandom % 3 != 0);
  end

  // Monitor: values seen here belong to the last edge (outputs) and the next edge (inputs)
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (cap_on && stb_q && cap_n < 8192) begin
        cap_bits[cap_n] = ser_out;
        cap_n++;
      end
      if (!stb_q && ser_out !== prev_out) hold_viol++;
      if (underrun) underruns++;
      if (s_ready && !bit_stb) ready_viol++;
    end
    prev_out = ser_out;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
  endtask

  task automatic push_stuffed(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(b[i]);
      if (b[i]) run_ones++; else run_ones = 0;
      if (run_ones == 5) begin exp_q.push_back(1'b0); run_ones = 0; end
    end
  endtask

  function automatic logic [31:0] ref_crc(input int k, input bit wide);
    logic [31:0] c;
    logic        fb;
    c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int n = 0; n < frm_len[k]; n++)
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ frm_d[k][n][i];
        c  = c >> 1;
        if (fb) c = c ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
      end
    return ~c;
  endfunction

  task automatic build_exp(input int k);
    logic [31:0] f;
    bit          nc;
    exp_q.delete();
    run_ones = 0;
    nc = cfg_crc_off | frm_nc[k];
    for (int r = 0; r < int'(cfg_pre_cnt); r++) push8(cfg_pre_pat);
    push8(8'h7E);
    if (frm_ab[k]) begin
      push_stuffed(frm_d[k][0]);
      push8(8'hFF);
    end else begin
      for (int n = 0; n < frm_len[k]; n++) push_stuffed(frm_d[k][n]);
      if (!nc) begin
        f = ref_crc(k, cfg_crc32);
        for (int n = 0; n < (cfg_crc32 ? 4 : 2); n++) push_stuffed(f[8*n +: 8]);
      end
      push8(8'h7E);
    end
  endtask

  function automatic logic fill_bit(input int j);
    logic [7:0] fo;
    fo = 8'h7E;
    return (cfg_fill_flags ? fo[j % 8] : 1'b1) ^ cfg_invert;
  endfunction

  task automatic match_frame(input string req, input int k, inout int ptr);
    int         n;
    bit         ok, found;
    logic [15:0] act, expv;
    build_exp(k);
    n = exp_q.size();
    found = 0;
    for (int g = 0; g <= 4096; g += 8) begin
      if (ptr + g + n > cap_n) break;
      ok = 1;
      for (int j = 0; j < g; j++) if (cap_bits[ptr + j] !== fill_bit(j)) ok = 0;
      if (!ok) break;
      for (int j = 0; j < n; j++)
        if (cap_bits[ptr + g + j] !== logic'(exp_q[j] ^ cfg_invert)) begin ok = 0; break; end
      if (ok) begin found = 1; ptr = ptr + g + n; break; end
    end
    total++;
    if (!found) begin
      bad++;
      for (int j = 0; j < 16; j++) begin
        act[j]  = (ptr + j < cap_n) ? cap_bits[ptr + j] : 1'bx;
        expv[j] = (j < n) ? logic'(exp_q[j] ^ cfg_invert) : 1'bx;
      end
      $display("FAIL %s frame %0d: no match from bit %0d actual=%h expected=%h", req, k, ptr, act, expv);
    end
  endtask

  task automatic check_tail(input string req, input int ptr);
    int n8, errs;
    n8 = ((cap_n - ptr) / 8) * 8;
    errs = 0;
    for (int j = 0; j < n8; j++) if (cap_bits[ptr + j] !== fill_bit(j)) errs++;
    chk(req, (n8 >= 16 && errs == 0) ? 32'd1 : 32'd0, 32'd1);
  endtask

  task automatic put_byte(input logic [7:0] d, input logic last, input logic nc);
    @(negedge clk);
    s_valid <= 1'b1; s_data <= d; s_last <= last; s_nocrc <= nc;
    #2;
    while (!s_ready) begin @(negedge clk); #2; end
    @(posedge clk);
  endtask

  task automatic send_frame(input int k);
    if (frm_ab[k]) begin
      put_byte(frm_d[k][0], 1'b0, frm_nc[k]);
    end else begin
      for (int n = 0; n < frm_len[k]; n++)
        put_byte(frm_d[k][n], n == frm_len[k] - 1, frm_nc[k]);
    end
    @(negedge clk);
    s_valid <= 1'b0;
    repeat ($urandom % 20) @(negedge clk);
  endtask

  task automatic rand_frame(input int k, input int maxlen);
    frm_len[k] = 1 + int'($urandom % maxlen);
    for (int n = 0; n < frm_len[k]; n++) frm_d[k][n] = 8'($urandom);
    frm_nc[k] = 0;
    frm_ab[k] = 0;
  endtask

  task automatic run_phase(input string req, input int nfr);
    int ptr;
    @(negedge clk);
    rst_n <= 1'b0; stb_en <= 1'b0; cap_on <= 1'b0;
    repeat (3) @(negedge clk);
    cap_n = 0;
    rst_n <= 1'b1; stb_en <= 1'b1; cap_on <= 1'b1;
    for (int k = 0; k < nfr; k++) send_frame(k);
    repeat (200) @(negedge clk);
    cap_on <= 1'b0;
    @(negedge clk);
    ptr = 8;
    for (int k = 0; k < 8; k++)
      chk("R10 first octet after reset is ones", {31'd0, cap_bits[k]}, {31'd0, 1'b1 ^ cfg_invert});
    for (int k = 0; k < nfr; k++) match_frame(req, k, ptr);
    check_tail({req, " R5 trailing fill"}, ptr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C1D));
    repeat (2) @(negedge clk);
    #1;
    chk("R10 ser_out in reset", {31'd0, ser_out}, 32'd1);
    chk("R10 s_ready in reset", {31'd0, s_ready}, 32'd0);
    chk("R10 underrun in reset", {31'd0, underrun}, 32'd0);

    // Phase 1: CRC-16, ones fill, no preamble; heavy stuffing, flag-like data, per-frame transparency
    cfg_crc32 = 0; cfg_fill_flags = 0; cfg_crc_off = 0; cfg_invert = 0; cfg_pre_cnt = 0;
    frm_len[0] = 3; frm_d[0][0] = 8'hFF; frm_d[0][1] = 8'hFF; frm_d[0][2] = 8'hFF;
    frm_nc[0] = 0; frm_ab[0] = 0;
    rand_frame(1, 8);
    rand_frame(2, 6); frm_nc[2] = 1;
    frm_len[3] = 2; frm_d[3][0] = 8'h7E; frm_d[3][1] = 8'h3F; frm_nc[3] = 0; frm_ab[3] = 0;
    run_phase("R1 R2 R3 R4 crc16 ones-fill", 4);

    // Phase 2: CRC-32, flag fill, preamble 0xA5 three times
    cfg_crc32 = 1; cfg_fill_flags = 1; cfg_pre_pat = 8'hA5; cfg_pre_cnt = 3;
    rand_frame(0, 10);
    frm_len[1] = 3; frm_d[1][0] = 8'hF8; frm_d[1][1] = 8'hFF; frm_d[1][2] = 8'h1F;
    frm_nc[1] = 0; frm_ab[1] = 0;
    rand_frame(2, 1);
    run_phase("R3 R5 R6 crc32 flag-fill preamble", 3);

    // Phase 3: transparent for every frame, single preamble
    cfg_crc32 = 0; cfg_fill_flags = 0; cfg_crc_off = 1; cfg_pre_pat = 8'h0F; cfg_pre_cnt = 1;
    rand_frame(0, 8);
    rand_frame(1, 12);
    run_phase("R4 R6 transparent", 2);

    // Phase 4: inverted line, flag fill
    cfg_crc_off = 0; cfg_fill_flags = 1; cfg_invert = 1; cfg_pre_pat = 8'h81; cfg_pre_cnt = 2;
    rand_frame(0, 8);
    rand_frame(1, 4);
    run_phase("R7 inversion", 2);

    // Phase 5: underrun after the first octet, then a normal frame
    cfg_invert = 0; cfg_fill_flags = 0; cfg_pre_cnt = 0;
    frm_len[0] = 1; frm_d[0][0] = 8'h12; frm_nc[0] = 0; frm_ab[0] = 1;
    rand_frame(1, 5);
    underruns = 0;
    run_phase("R9 abort then recover", 2);
    chk("R9 underrun pulse count", underruns, 32'd1);

    chk("R8 s_ready only with bit_stb", ready_viol, 32'd0);
    chk("R8 ser_out changes only after a strobe", hold_viol, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule